// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is the serial front end of a small register file. A host selects it by raising an active-high chip select, toggles a serial clock and moves data on one data line. The line is split here into an input, an output and an output enable, which the pad ring combines. All serial signals are oversampled by a faster system clock. Edges of the serial clock are found after a synchronizer, so the whole block runs in the system clock domain.

Each transfer opens with a command byte. Its top bit chooses write (1) or read (0), and its low seven bits give a starting address. One or more data bytes follow. After every data byte the address steps forward, so a single command can cover a burst. The register file sits behind a plain port: an address, write data, a write strobe and combinational read data. The block also obeys a write-protect level that the register file reports. It raises a hold flag so that an externally refreshed result register stays frozen while the host is reading it.

Top module: `tw_slave`

## Requirements
- R1: After reset, `sdio_oe`, `reg_we` and `conv_hold` are all low.
- R2: The command byte arrives LSB first, sampled on rising serial-clock edges. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6:0 hold the starting address.
- R3: A write data byte (LSB first) is committed with a single-cycle `reg_we` pulse. `reg_addr` holds the byte's target address during that pulse, and the pulse comes only after all 8 bits have been received.
- R4: In a read, each data bit is driven LSB first and changes only after a falling serial-clock edge. `sdio_oe` stays high through the data bits of a read.
- R5: After each data byte the address advances by one. Address 0x0E is followed by 0x00.
- R6: Addresses 0x0F to 0x7F are reserved. They read as 0x00 whatever `reg_rdata` holds, and they never produce `reg_we`. Within that range the address advances modulo 128, so 0x7F is followed by 0x00.
- R7: While `wp_in` is 1, writes to every address except the control register 0x0B are suppressed.
- R8: The control register 0x0B stays writable while protected, so the protection can be cleared. Later bytes of the same burst then see the new `wp_in`.
- R9: A data byte cut short by chip select falling before its eighth bit is discarded and writes nothing.
- R10: `conv_hold` is high while a read transfer is positioned on address 0x0E. It falls when that byte completes or when chip select drops.
- R11: Within three system clocks of chip select going low, `sdio_oe` and `conv_hold` are low. The next transfer begins again with a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial data to the host |
| sdio_oe | output | 1 | Drive enable for the data pad |
| reg_addr | output | 7 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe, one cycle |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |
| wp_in | input | 1 | Write-protect level from the control register |
| conv_hold | output | 1 | Freeze request for the result register |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 7-bit address, 0x0E as the last real register, 0x0B as the control register and two synchronizer stages. The serial clock runs at eight system clocks per half period. With the full 7-bit address space in place, a burst starting at 0x7E walks into the modulo-128 wrap. A burst from 0x0C or 0x0D crosses the 0x0E-to-0x00 wrap and the hold window in one transfer. A burst from 0x0A shows protection being lifted partway through a burst.

// File: rtl/tw_pkg.sv
// Shared types for the three-wire slave.
package tw_pkg;
    // Where a transfer stands: still collecting the command, or past it.
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } tw_phase_e;
endpackage

// File: rtl/tw_sync_edge.sv
// Brings the three asynchronous serial pins into the system clock domain.
// Also flags rising and falling edges of the serial clock.
// Assumes STAGES >= 2. Assumes each serial clock level lasts at least
// STAGES+2 system clocks, so no edge is lost.
module tw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_raw,
    input  logic sclk_raw,
    input  logic sdi_raw,
    output logic cs_s,
    output logic sdi_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw_vec;
    logic [NSIG-1:0] synced;
    logic            sclk_d;

    assign raw_vec = {sdi_raw, sclk_raw, cs_raw};

    genvar g;
    generate
        for (g = 0; g < NSIG; g++) begin : g_sig
            logic [STAGES-1:0] chain;
            // Shift one pin through its synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw_vec[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    // Keep last synchronized serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= synced[1];
    end

    assign cs_s      = synced[0];
    assign sdi_s     = synced[2];
    assign sclk_rise = synced[1] & ~sclk_d;
    assign sclk_fall = ~synced[1] & sclk_d;
endmodule

// File: rtl/tw_deser.sv
// Collects serial bits, LSB first, into bytes on rising serial clock edges.
// Marks whether each finished byte was the command or a data byte.
// Assumes synchronized inputs. Chip select low clears all progress.
module tw_deser
    import tw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    output tw_phase_e         phase,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              byte_done,
    output logic              byte_is_cmd,
    output logic [DATA_W-1:0] byte_val
);
    logic [DATA_W-1:0] rx;

    // Shift in bits, count them, and pulse when a byte is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx          <= '0;
            bit_cnt     <= '0;
            byte_done   <= 1'b0;
            byte_is_cmd <= 1'b0;
            phase       <= PH_CMD;
        end else if (!cs_s) begin
            bit_cnt     <= '0;
            byte_done   <= 1'b0;
            byte_is_cmd <= 1'b0;
            phase       <= PH_CMD;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                rx <= {sdi_s, rx[DATA_W-1:1]};
                if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                    bit_cnt     <= '0;
                    byte_done   <= 1'b1;
                    byte_is_cmd <= (phase == PH_CMD);
                    phase       <= PH_DATA;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign byte_val = rx;
endmodule

// File: rtl/tw_access.sv
// Turns decoded bytes into register file accesses. Holds the address
// pointer and the direction. Applies write protection and reserved
// address rules, feeds the read shifter and raises the result-hold flag.
// Assumes ADDR_W < DATA_W. The command direction bit is bit DATA_W-1.
module tw_access
    import tw_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 7,
    parameter int CNT_W     = 3,
    parameter int LAST_ADDR = 14,
    parameter int CTRL_ADDR = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_fall,
    input  tw_phase_e         phase,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              byte_done,
    input  logic              byte_is_cmd,
    input  logic [DATA_W-1:0] byte_val,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              wp_in,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              conv_hold
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);
    localparam logic [ADDR_W-1:0] CTRL = ADDR_W'(CTRL_ADDR);

    logic [ADDR_W-1:0] ptr;
    logic              wr_mode;
    logic              load_pend;
    logic              adv_pend;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] tx;
    logic              sdo_q;
    logic              oe_q;
    logic              in_range;
    logic              write_ok;
    logic [DATA_W-1:0] rd_val;

    // Step the pointer: wrap after the last register, else modulo 2^ADDR_W.
    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
        return (a == LAST) ? '0 : a + 1'b1;
    endfunction

    // Decide whether the current address may be written or read.
    always_comb begin
        in_range = (ptr <= LAST);
        write_ok = in_range && (!wp_in || ptr == CTRL);
        rd_val   = in_range ? reg_rdata : '0;
    end

    // Sequence the pointer, register writes, read loads and output bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            wr_mode   <= 1'b1;
            load_pend <= 1'b0;
            adv_pend  <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
            tx        <= '0;
            sdo_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (adv_pend) begin
                ptr      <= next_addr(ptr);
                adv_pend <= 1'b0;
            end
            if (!cs_s) begin
                wr_mode   <= 1'b1;
                load_pend <= 1'b0;
                oe_q      <= 1'b0;
            end else begin
                if (load_pend) begin
                    tx        <= rd_val;
                    load_pend <= 1'b0;
                end
                if (byte_done) begin
                    if (byte_is_cmd) begin
                        ptr       <= byte_val[ADDR_W-1:0];
                        wr_mode   <= byte_val[DATA_W-1];
                        load_pend <= ~byte_val[DATA_W-1];
                    end else if (wr_mode) begin
                        we_q     <= write_ok;
                        wdata_q  <= byte_val;
                        adv_pend <= 1'b1;
                    end else begin
                        ptr       <= next_addr(ptr);
                        load_pend <= 1'b1;
                    end
                end
                if (sclk_fall && phase == PH_DATA && !wr_mode) begin
                    sdo_q <= tx[bit_cnt];
                    oe_q  <= 1'b1;
                end
            end
        end
    end

    assign reg_addr  = ptr;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign sdo       = sdo_q;
    assign sdo_oe    = oe_q & cs_s;
    assign conv_hold = cs_s & (phase == PH_DATA) & ~wr_mode & (ptr == LAST);
endmodule

// File: rtl/tw_slave.sv
// Three-wire register access slave: synchronizer, byte collector and
// access sequencer. Everything runs on clk. The serial clock must be
// slow enough that each level spans several system clocks.
module tw_slave
    import tw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LAST_ADDR   = 14,
    parameter int CTRL_ADDR   = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sclk,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic [DATA_W-2:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              wp_in,
    output logic              conv_hold
);
    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W);

    logic              cs_s;
    logic              sdi_s;
    logic              sclk_rise;
    logic              sclk_fall;
    tw_phase_e         phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic              byte_done;
    logic              byte_is_cmd;
    logic [DATA_W-1:0] byte_val;

    tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_raw    (cs),
        .sclk_raw  (sclk),
        .sdi_raw   (sdio_in),
        .cs_s      (cs_s),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    tw_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .sdi_s       (sdi_s),
        .sclk_rise   (sclk_rise),
        .phase       (phase),
        .bit_cnt     (bit_cnt),
        .byte_done   (byte_done),
        .byte_is_cmd (byte_is_cmd),
        .byte_val    (byte_val)
    );

    tw_access #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .LAST_ADDR (LAST_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .sclk_fall   (sclk_fall),
        .phase       (phase),
        .bit_cnt     (bit_cnt),
        .byte_done   (byte_done),
        .byte_is_cmd (byte_is_cmd),
        .byte_val    (byte_val),
        .reg_rdata   (reg_rdata),
        .wp_in       (wp_in),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .sdo         (sdio_out),
        .sdo_oe      (sdio_oe),
        .conv_hold   (conv_hold)
    );
endmodule

// File: rtl/tw_slave_chk.sv
// Property checker for tw_slave, attached by bind. It watches the
// register port, the pad enable and the hold flag.
module tw_slave_chk #(
    parameter int ADDR_W    = 7,
    parameter int LAST_ADDR = 14,
    parameter int CTRL_ADDR = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              wp_in,
    input logic              sdio_oe,
    input logic              conv_hold
);
    // R6
    reserved_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_addr <= ADDR_W'(LAST_ADDR));

    // R7
    protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (!$past(wp_in) || reg_addr == ADDR_W'(CTRL_ADDR)));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !reg_we);

    // R10
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_hold |-> !reg_we);
endmodule

bind tw_slave tw_slave_chk #(
    .ADDR_W    (DATA_W - 1),
    .LAST_ADDR (LAST_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .wp_in     (wp_in),
    .sdio_oe   (sdio_oe),
    .conv_hold (conv_hold)
);

// File: tb/tw_slave_test.sv
module tw_slave_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       sclk = 1'b0;
    logic       sdio_in = 1'b0;
    logic       sdio_out;
    logic       sdio_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       wp_in;
    logic       conv_hold;

    logic [7:0] mem [15];
    logic [7:0] exp_mem [15];
    logic [7:0] wbuf [8];
    bit   [7:0] rhold;
    int         checks = 0;
    int         errors = 0;
    int         cs_low_cnt = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    tw_slave uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .wp_in(wp_in), .conv_hold(conv_hold)
    );

    // Behavioural register file; reserved addresses return junk on purpose.
    assign reg_rdata = (reg_addr < 7'd15) ? mem[reg_addr[3:0]] : 8'hA5;
    assign wp_in     = mem[11][6];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 15; i++) mem[i] <= 8'(i * 3 + 1);
        end else if (reg_we && reg_addr < 7'd15) begin
            mem[reg_addr[3:0]] <= reg_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // R6: any write strobe must target a real register.
    always @(posedge clk) begin
        if (rst_n && reg_we) check(reg_addr < 7'd15, "R6 write strobe address", int'(reg_addr), 14);
    end

    // R11: once chip select has been low for a while, pad and hold stay quiet.
    always @(negedge clk) begin
        if (cs) cs_low_cnt = 0;
        else cs_low_cnt++;
        if (rst_n && cs_low_cnt >= 3)
            check(!sdio_oe && !conv_hold, "R11 idle outputs", int'({sdio_oe, conv_hold}), 0);
    end

    function automatic int step(input int p);
        return (p == 14) ? 0 : ((p + 1) % 128);
    endfunction

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sdio_in = b[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic recv_bits(output logic [7:0] v, output bit oe_ok, output bit hold_seen, input int n);
        v = 8'h00; oe_ok = 1; hold_seen = 0; sdio_in = 1'b0;
        for (int i = 0; i < n; i++) begin
            repeat (HALF) @(negedge clk);
            v[i] = sdio_out;
            if (!sdio_oe) oe_ok = 0;
            if (conv_hold) hold_seen = 1;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        cs = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic compare_mem(input string req);
        for (int i = 0; i < 15; i++)
            check(mem[i] === exp_mem[i], req, int'(mem[i]), int'(exp_mem[i]));
    endtask

    // Write burst plus model: protection read from the model control byte.
    task automatic write_xfer(input logic [6:0] a, input int n, input string req);
        int p;
        cs_on();
        send_bits({1'b1, a}, 8);
        for (int k = 0; k < n; k++) send_bits(wbuf[k], 8);
        cs_off();
        p = int'(a);
        for (int k = 0; k < n; k++) begin
            if (p <= 14 && (exp_mem[11][6] == 1'b0 || p == 11)) exp_mem[p] = wbuf[k];
            p = step(p);
        end
        compare_mem(req);
    endtask

    task automatic read_xfer(input logic [6:0] a, input int n, input string req);
        int p;
        logic [7:0] v;
        logic [7:0] e;
        bit oe_ok;
        bit hs;
        cs_on();
        send_bits({1'b0, a}, 8);
        p = int'(a);
        for (int k = 0; k < n; k++) begin
            recv_bits(v, oe_ok, hs, 8);
            e = (p <= 14) ? exp_mem[p] : 8'h00;
            check(v === e, req, int'(v), int'(e));
            check(oe_ok, "R4 drive enable during read", int'(oe_ok), 1);
            rhold[k] = hs;
            p = step(p);
        end
        cs_off();
    endtask

    initial begin
        logic [7:0] v;
        bit oe_ok;
        bit hs;
        for (int i = 0; i < 15; i++) exp_mem[i] = 8'(i * 3 + 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!sdio_oe && !reg_we && !conv_hold, "R1 reset outputs",
              int'({sdio_oe, reg_we, conv_hold}), 0);

        // R2 R3: single write, then read back (R4)
        wbuf[0] = 8'h5A;
        write_xfer(7'h02, 1, "R3 single write");
        read_xfer(7'h02, 1, "R2 R4 single read");

        // R5: burst write across the 0x0E wrap, then read across it
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C; wbuf[2] = 8'h96; wbuf[3] = 8'h81;
        write_xfer(7'h0C, 4, "R5 burst write wrap");
        read_xfer(7'h0D, 3, "R5 burst read wrap");
        // R10
        check(rhold[0] == 1'b0, "R10 no hold at 0x0D", int'(rhold[0]), 0);
        check(rhold[1] == 1'b1, "R10 hold at 0x0E", int'(rhold[1]), 1);
        check(rhold[2] == 1'b0, "R10 hold released after byte", int'(rhold[2]), 0);

        // R6: reserved write ignored, reserved reads zero, modulo wrap
        wbuf[0] = 8'hFF;
        write_xfer(7'h20, 1, "R6 reserved write");
        read_xfer(7'h7E, 3, "R6 reserved read and wrap");

        // R7: set protection, then a blocked write
        wbuf[0] = 8'h40;
        write_xfer(7'h0B, 1, "R7 set protect");
        wbuf[0] = 8'h11;
        write_xfer(7'h02, 1, "R7 protected write blocked");
        read_xfer(7'h02, 1, "R7 protected value kept");

        // R8: burst 0x0A..0x0C: 0x0A blocked, 0x0B clears protection, 0x0C lands
        wbuf[0] = 8'h77; wbuf[1] = 8'h00; wbuf[2] = 8'h55;
        write_xfer(7'h0A, 3, "R8 control writable and clearing");

        // R9: partial data byte
        cs_on();
        send_bits(8'h83, 8);
        send_bits(8'hFF, 5);
        cs_off();
        compare_mem("R9 partial byte discarded");

        // R11: fresh transfer after the abort starts with a command
        wbuf[0] = 8'h3C;
        write_xfer(7'h03, 1, "R11 new transfer after abort");

        // R10: read of 0x0E cut short by chip select
        cs_on();
        send_bits(8'h0E, 8);
        recv_bits(v, oe_ok, hs, 3);
        check(hs, "R10 hold during partial read", int'(hs), 1);
        check(v[2:0] === exp_mem[14][2:0], "R4 partial read bits", int'(v[2:0]), int'(exp_mem[14][2:0]));
        cs_off();
        check(!conv_hold, "R10 hold ends with chip select", int'(conv_hold), 0);
        check(!sdio_oe, "R11 pad released", int'(sdio_oe), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule